// File: doc/BRIEF.md
# Region Isolation Controller

This block sits beside a reconfigurable region and keeps that region apart from the rest of the chip while the region is rewritten. Software uses a small 32-bit register port. Writing a freeze request makes the block drive a freeze line toward the region. Once the region acknowledges, a sticky "frozen" status bit is set. While the region is frozen, software may hold it in reset through a control bit. To bring the region back, software clears control and writes an unfreeze request. The block then drops freeze and reset, raises an unfreeze request, and sets a sticky "running" status bit when the region acknowledges.

The block checks every control write against the current state. A write that sets more than one request bit is refused and logged. So is an unfreeze request or a reset request made while the region is not frozen. Each cause has its own bit in a capture register, and writing one to that register clears it. A refused write leaves the state and the control register exactly as they were. A read-only identifier register returns one of two fixed codes, chosen by a parameter.

Top module: `region_iso_ctrl`

## Requirements
- R1: After reset, status reads 2 (bit 1 "running" set, bit 0 "frozen" clear). Control, the capture register and all three region outputs are zero.
- R2: Registers sit at byte addresses 0 (status), 4 (control), 8 (capture) and 12 (identifier). The identifier reads 0xAD000003 by default, or 2 when LEGACY_ID is set. Any other address reads 0. Reads with rd_i low return 0. Writes to status and to the identifier change nothing.
- R3: A legal control write of value 1 while running raises freeze_req_o in the next cycle and clears both status bits. Status bit 0 is set only in the cycle after freeze_ack_i was sampled high.
- R4: Status bits 0 and 1 are never set at the same time.
- R5: While frozen, region_rst_o follows control bit 1 (value 2 requests reset). Writing control to 0 releases region reset and leaves the region frozen.
- R6: A control write of 4 while frozen drops freeze_req_o and region_rst_o, raises thaw_req_o and clears status. Status then reads 2 in the cycle after thaw_ack_i is sampled high. A later control write of 0 keeps status at 2.
- R7: A control write with more than one of bits 0..2 set sets capture bit 0.
- R8: A control write of 4 while not frozen sets capture bit 1. A control write of 2 while not frozen sets capture bit 2.
- R9: A refused control write changes neither the state nor the control register. Control keeps its last legal value.
- R10: A write to the capture register with bit 0 set clears every capture bit. A write with bit 0 clear leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i while rd_i is high |
| freeze_req_o | output | 1 | Freeze the region's outputs |
| freeze_ack_i | input | 1 | Region reports it is frozen |
| thaw_req_o | output | 1 | Ask the region to resume |
| thaw_ack_i | input | 1 | Region reports it has resumed |
| region_rst_o | output | 1 | Reset into the region |

## Verification
A wrong state shows up in the status read and on the freeze, thaw and reset lines in the very next cycle. The stimulus therefore reads the registers and samples the outputs right after every write and every acknowledge. Withholding the acknowledge for several cycles exposes a done bit that is set too early. A sweep of all eight control values, run both while running and while frozen, exposes a mis-decoded refusal. It also shows whether a refused write still moved the state, because the control readback and the status read would change.

// File: rtl/region_iso_pkg.sv
package region_iso_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_FREEZING = 2'd1,
    ST_FROZEN   = 2'd2,
    ST_THAWING  = 2'd3
  } iso_state_e;

  localparam int unsigned REQ_W = 3;
  localparam int unsigned REQ_FREEZE = 0;
  localparam int unsigned REQ_RESET  = 1;
  localparam int unsigned REQ_THAW   = 2;

  localparam int unsigned CAUSE_MULTI = 0;
  localparam int unsigned CAUSE_THAW  = 1;
  localparam int unsigned CAUSE_RESET = 2;

  localparam int unsigned OFF_STATUS = 0;
  localparam int unsigned OFF_CTRL   = 4;
  localparam int unsigned OFF_CAUSE  = 8;
  localparam int unsigned OFF_ID     = 12;

  localparam logic [31:0] ID_NEW    = 32'hAD00_0003;
  localparam logic [31:0] ID_LEGACY = 32'd2;
endpackage

// File: rtl/region_iso_check.sv
module region_iso_check
  import region_iso_pkg::*;
(
  input  logic             ctrl_wr_i,
  input  logic [REQ_W-1:0] req_i,
  input  logic             frozen_i,
  output logic             accept_o,
  output logic [REQ_W-1:0] cause_o
);
  logic multi;

  assign multi = (req_i[0] & req_i[1]) | (req_i[0] & req_i[2]) | (req_i[1] & req_i[2]);

  always_comb begin
    cause_o              = '0;
    cause_o[CAUSE_MULTI] = ctrl_wr_i & multi;
    cause_o[CAUSE_THAW]  = ctrl_wr_i & ~multi & req_i[REQ_THAW]  & ~frozen_i;
    cause_o[CAUSE_RESET] = ctrl_wr_i & ~multi & req_i[REQ_RESET] & ~frozen_i;
  end

  assign accept_o = ctrl_wr_i & (cause_o == '0);
endmodule

// File: rtl/region_iso_fsm.sv
module region_iso_fsm
  import region_iso_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [REQ_W-1:0] req_i,
  input  logic             freeze_ack_i,
  input  logic             thaw_ack_i,
  output iso_state_e       state_o,
  output logic [REQ_W-1:0] ctrl_o,
  output logic             freeze_req_o,
  output logic             thaw_req_o,
  output logic             region_rst_o
);
  iso_state_e       state_q, state_d;
  logic [REQ_W-1:0] ctrl_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:      if (accept_i && req_i[REQ_FREEZE]) state_d = ST_FREEZING;
      ST_FREEZING: if (freeze_ack_i) state_d = ST_FROZEN;
      ST_FROZEN:   if (accept_i && req_i[REQ_THAW]) state_d = ST_THAWING;
      ST_THAWING:  if (thaw_ack_i) state_d = ST_RUN;
      default:     state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      ctrl_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept_i) ctrl_q <= req_i;
    end
  end

  assign state_o      = state_q;
  assign ctrl_o       = ctrl_q;
  assign freeze_req_o = (state_q == ST_FREEZING) || (state_q == ST_FROZEN);
  assign thaw_req_o   = (state_q == ST_THAWING);
  assign region_rst_o = (state_q == ST_FROZEN) && ctrl_q[REQ_RESET];

  // R3
  frz_done_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FREEZING && !freeze_ack_i) |=> state_q == ST_FREEZING);
  // R6
  thaw_done_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_THAWING && !thaw_ack_i) |=> state_q == ST_THAWING);
endmodule

// File: rtl/region_iso_rdmux.sv
module region_iso_rdmux
  import region_iso_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic [1:0]        status_i,
  input  logic [REQ_W-1:0]  ctrl_i,
  input  logic [REQ_W-1:0]  cause_i,
  input  logic [31:0]       id_i,
  output logic [31:0]       rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_W'(OFF_STATUS): rdata_o = 32'(status_i);
        ADDR_W'(OFF_CTRL):   rdata_o = 32'(ctrl_i);
        ADDR_W'(OFF_CAUSE):  rdata_o = 32'(cause_i);
        ADDR_W'(OFF_ID):     rdata_o = id_i;
        default:             rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/region_iso_ctrl.sv
module region_iso_ctrl
  import region_iso_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter bit          LEGACY_ID = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              freeze_req_o,
  input  logic              freeze_ack_i,
  output logic              thaw_req_o,
  input  logic              thaw_ack_i,
  output logic              region_rst_o
);
  localparam logic [31:0] ID_VAL = LEGACY_ID ? ID_LEGACY : ID_NEW;

  iso_state_e       state;
  logic [REQ_W-1:0] ctrl, cause_new, cause_q;
  logic             ctrl_wr, cause_wr, accept, frozen;
  logic [1:0]       status;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[31:REQ_W];
  assign ctrl_wr  = wr_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign cause_wr = wr_i && (addr_i == ADDR_W'(OFF_CAUSE));
  assign frozen   = (state == ST_FROZEN);
  assign status   = {state == ST_RUN, frozen};

  region_iso_check u_check (
    .ctrl_wr_i (ctrl_wr),
    .req_i     (wdata_i[REQ_W-1:0]),
    .frozen_i  (frozen),
    .accept_o  (accept),
    .cause_o   (cause_new)
  );

  region_iso_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .req_i        (wdata_i[REQ_W-1:0]),
    .freeze_ack_i (freeze_ack_i),
    .thaw_ack_i   (thaw_ack_i),
    .state_o      (state),
    .ctrl_o       (ctrl),
    .freeze_req_o (freeze_req_o),
    .thaw_req_o   (thaw_req_o),
    .region_rst_o (region_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cause_q <= '0;
    else if (cause_wr && wdata_i[0]) cause_q <= '0;
    else                             cause_q <= cause_q | cause_new;
  end

  region_iso_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .status_i (status),
    .ctrl_i   (ctrl),
    .cause_i  (cause_q),
    .id_i     (ID_VAL),
    .rdata_o  (rdata_o)
  );

  // R4
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status[0] && status[1]));
  // R9
  refused_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && cause_new != '0) |=> (ctrl == $past(ctrl)) && (state == $past(state)));
  // R10
  cause_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_wr && wdata_i[0]) |=> cause_q == '0);
  // R5
  rst_from_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(region_rst_o) |-> $past(ctrl_wr && wdata_i[REQ_RESET]));
  // R6
  thaw_drops_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(thaw_req_o) |-> !freeze_req_o && !region_rst_o);
endmodule

// File: tb/tb_region_iso_ctrl.sv
module tb_region_iso_ctrl;
  localparam logic [31:0] EXP_ID = 32'hAD00_0003;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        frz_req, frz_ack = 1'b0, thaw_req, thaw_ack = 1'b0, reg_rst;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  region_iso_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .freeze_req_o(frz_req),
    .freeze_ack_i(frz_ack), .thaw_req_o(thaw_req), .thaw_ack_i(thaw_ack),
    .region_rst_o(reg_rst)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  function automatic logic [31:0] exp_cause_run(input int v);
    if ($countones(v[2:0]) > 1) return 32'd1;
    if (v == 4) return 32'd2;
    if (v == 2) return 32'd4;
    return 32'd0;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [2:0]  exp_ctrl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(0, d); check("R1 status", d, 2);
    rd_reg(4, d); check("R1 ctrl", d, 0);
    rd_reg(8, d); check("R1 cause", d, 0);
    check("R1 outputs", {29'd0, frz_req, thaw_req, reg_rst}, 0);

    // R2 address sweep
    for (int a = 0; a < 16; a++) begin
      rd_reg(a[3:0], d);
      check("R2 read map", d, (a == 0) ? 32'd2 : (a == 12) ? EXP_ID : 32'd0);
    end
    @(negedge clk); addr = 4'd12; #1 check("R2 no rd", rdata, 0);
    wr_reg(0, 32'hFFFF_FFFF); wr_reg(12, 32'hFFFF_FFFF);
    rd_reg(0, d);  check("R2 status ro", d, 2);
    rd_reg(12, d); check("R2 id ro", d, EXP_ID);

    // R7 R8 R9 sweep while running
    for (int v = 0; v < 8; v++) begin
      if (v == 1) continue;
      wr_reg(4, v);
      rd_reg(8, d); check("R7/R8 cause running", d, exp_cause_run(v));
      rd_reg(4, d); check("R9 ctrl kept", d, 0);
      rd_reg(0, d); check("R9 status kept", d, 2);
      check("R9 outputs", {29'd0, frz_req, thaw_req, reg_rst}, 0);
      wr_reg(8, 1);
      rd_reg(8, d); check("R10 cleared", d, 0);
    end
    wr_reg(4, 6);
    wr_reg(8, 2);
    rd_reg(8, d); check("R10 bit0 clear keeps", d, 1);
    wr_reg(8, 1);

    // R3 freeze
    wr_reg(4, 1);
    check("R3 freeze out", frz_req, 1);
    rd_reg(0, d); check("R3 status mid", d, 0);
    repeat (3) @(negedge clk);
    rd_reg(0, d); check("R3 no ack", d, 0);
    frz_ack = 1'b1;
    @(negedge clk); frz_ack = 1'b0;
    rd_reg(0, d); check("R3 frozen", d, 1);
    check("R3 freeze held", frz_req, 1);

    // R5 R7 R9 sweep while frozen
    exp_ctrl = 3'd1;
    for (int v = 0; v < 8; v++) begin
      if (v == 4) continue;
      wr_reg(4, v);
      if ($countones(v[2:0]) <= 1) exp_ctrl = v[2:0];
      rd_reg(8, d); check("R7 cause frozen", d, ($countones(v[2:0]) > 1) ? 32'd1 : 32'd0);
      rd_reg(4, d); check("R9 ctrl frozen", d, 32'(exp_ctrl));
      check("R5 region reset", reg_rst, exp_ctrl[1]);
      rd_reg(0, d); check("R4 status frozen", d, 1);
      wr_reg(8, 1);
    end
    wr_reg(4, 2); check("R5 reset on", reg_rst, 1);
    wr_reg(4, 0); check("R5 reset off", reg_rst, 0);
    check("R5 still frozen", frz_req, 1);

    // R6 thaw
    wr_reg(4, 2);
    wr_reg(4, 4);
    check("R6 outputs", {29'd0, frz_req, thaw_req, reg_rst}, 3'b010);
    rd_reg(0, d); check("R6 status mid", d, 0);
    repeat (2) @(negedge clk);
    rd_reg(0, d); check("R6 no ack", d, 0);
    thaw_ack = 1'b1;
    @(negedge clk); thaw_ack = 1'b0;
    rd_reg(0, d); check("R6 running", d, 2);
    check("R6 thaw drop", thaw_req, 0);
    wr_reg(4, 0);
    rd_reg(0, d); check("R6 stays", d, 2);
    wr_reg(4, 4);
    rd_reg(8, d); check("R8 thaw after run", d, 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule